// File: doc/BRIEF.md
# Operand-Capturing Reservation Station Array

This block holds the waiting operations for one class of functional unit inside a tag-renamed out-of-order scheduler. Dispatch hands it an operation with two source operands. Each operand arrives as a plain value, or as the rename tag of the station that will produce it. A station that is still waiting watches the single result broadcast bus and takes the broadcast value when the tag on the bus equals the tag it holds. Once both operands of a station hold values, that station may be handed to the functional unit in a cycle when the unit reports that it is free.

Every station's own number is its rename tag. The array's stations carry the consecutive tags `TAG_BASE` to `TAG_BASE+N_ENTRIES-1`. With the defaults, an adder array uses tags 1 to 3 and a multiplier array built with `N_ENTRIES=2, TAG_BASE=4` uses tags 4 to 5. Tag 0 is never a producer and means "operand already valid". The array tells dispatch which tag the next accepted operation will receive, and it raises `full` so that dispatch can stall.

Top module: `rs_array`

## Requirements
- R1: After reset every station is empty: `full` is 0, `iss_valid` is 0 and `disp_slot_tag` equals `TAG_BASE`.
- R2: `full` is 1 exactly when all `N_ENTRIES` stations are occupied. A dispatch presented while `full` is 1 is ignored and leaves no trace in later issues.
- R3: A dispatch is written into the lowest-numbered free station. While `full` is 0, `disp_slot_tag` equals `TAG_BASE` plus that station's index.
- R4: A dispatched operand whose tag is 0 is stored as a valid value. An operand with a nonzero tag waits for its producer.
- R5: When `bc_valid` is 1 and `bc_tag` equals a waiting operand's tag, the station takes `bc_data` as that operand's value at the clock edge. The station can issue from the following cycle.
- R6: If a dispatched operand's tag equals `bc_tag` while `bc_valid` is 1 in the dispatch cycle, the station stores `bc_data` as that operand's value, so the wakeup is not lost.
- R7: `iss_valid` is 1 only when `fu_free` is 1 and some station has both operands valid. The issue port then shows that station's op code, both operand values and its own tag as the destination.
- R8: When several stations are ready, the one that was dispatched earliest is issued. Relative age is kept in a per-station counter.
- R9: A station that issues is empty after that clock edge, so a dispatch in the next cycle can use it.
- R10: A broadcast with `bc_valid` 0, or with a tag that no waiting operand holds, changes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch presents an operation |
| disp_op | input | 4 | Operation code |
| disp_tag_a | input | 3 | Producer tag of operand A, 0 if value valid |
| disp_val_a | input | 16 | Value of operand A |
| disp_tag_b | input | 3 | Producer tag of operand B, 0 if value valid |
| disp_val_b | input | 16 | Value of operand B |
| full | output | 1 | No free station; dispatch must stall |
| disp_slot_tag | output | 3 | Tag the next accepted dispatch receives |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 3 | Tag of the broadcast producer |
| bc_data | input | 16 | Broadcast result value |
| fu_free | input | 1 | Functional unit can accept an operation |
| iss_valid | output | 1 | An operation is handed to the unit this cycle |
| iss_op | output | 4 | Issued operation code |
| iss_a | output | 16 | Issued operand A value |
| iss_b | output | 16 | Issued operand B value |
| iss_tag | output | 3 | Destination tag (station number) of the issued operation |

## Verification
Two events can meet in one cycle: an operation is written into a station while its producer's result is on the broadcast bus. The directed part of the bench provokes this by dispatching an operand tagged 5 while tag 5 is broadcast. It then judges the result by the operand value that later leaves on the issue port. The random phase produces many more such meetings, together with issue-and-reallocate in adjacent cycles. A bench model that orders stations by dispatch sequence number decides the expected issue on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_TAG_W  = 3;
  localparam int RS_DATA_W = 16;
  localparam int RS_OP_W   = 4;

  typedef logic [RS_TAG_W-1:0]  tag_t;
  typedef logic [RS_DATA_W-1:0] data_t;
  typedef logic [RS_OP_W-1:0]   op_t;

  typedef struct packed {
    tag_t  tag;   // 0 means val holds the operand
    data_t val;
  } opnd_t;

  // Operand after watching the result bus for one cycle.
  function automatic opnd_t opnd_next(opnd_t cur, logic bc_v, tag_t bc_t, data_t bc_d);
    opnd_t nxt;
    nxt = cur;
    if (cur.tag != '0 && bc_v && bc_t == cur.tag) begin
      nxt.tag = '0;
      nxt.val = bc_d;
    end
    return nxt;
  endfunction

  // Relative age: grows when a younger station arrives and shrinks when an
  // older station leaves, so the occupied stations hold 0..count-1.
  function automatic int unsigned age_next(int unsigned age, logic disp,
                                           logic iss, int unsigned iss_age);
    int unsigned a;
    a = age;
    if (disp) a = a + 1;
    if (iss && age > iss_age) a = a - 1;
    return a;
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int AGE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  op_t              d_op,
  input  opnd_t            d_a,
  input  opnd_t            d_b,
  input  logic             bc_valid,
  input  tag_t             bc_tag,
  input  data_t            bc_data,
  input  logic             issue_i,
  input  logic             disp_ev,
  input  logic             iss_ev,
  input  logic [AGE_W-1:0] iss_age,
  output logic             busy_o,
  output logic             ready_o,
  output op_t              op_o,
  output data_t            a_o,
  output data_t            b_o,
  output logic [AGE_W-1:0] age_o
);
  logic             busy_q;
  op_t              op_q;
  opnd_t            a_q, b_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      age_q  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= d_op;
      a_q    <= opnd_next(d_a, bc_valid, bc_tag, bc_data);
      b_q    <= opnd_next(d_b, bc_valid, bc_tag, bc_data);
      age_q  <= '0;
    end else if (busy_q) begin
      if (issue_i) busy_q <= 1'b0;
      a_q   <= opnd_next(a_q, bc_valid, bc_tag, bc_data);
      b_q   <= opnd_next(b_q, bc_valid, bc_tag, bc_data);
      age_q <= AGE_W'(age_next(int'(age_q), disp_ev, iss_ev, int'(iss_age)));
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && a_q.tag == '0 && b_q.tag == '0;
  assign op_o    = op_q;
  assign a_o     = a_q.val;
  assign b_o     = b_q.val;
  assign age_o   = age_q;

  // R5: a waiting operand takes the matching broadcast value
  p_capture_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc_i && a_q.tag != '0 && bc_valid && bc_tag == a_q.tag)
    |=> (a_q.tag == '0 && a_q.val == $past(bc_data)));
  p_capture_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc_i && b_q.tag != '0 && bc_valid && bc_tag == b_q.tag)
    |=> (b_q.tag == '0 && b_q.val == $past(bc_data)));
  // R9: an issued station is empty after the edge
  p_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> !busy_q);
  // R2: only an empty station is written
  p_alloc_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !busy_q);
  // R7: only a station with both operands valid is issued
  p_issue_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (busy_q && a_q.tag == '0 && b_q.tag == '0));
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     busy,
  output logic [N-1:0]     pick_vec,
  output logic [IDX_W-1:0] pick_idx,
  output logic             any_free
);
  always_comb begin
    pick_vec = '0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        pick_vec    = '0;
        pick_vec[i] = 1'b1;
        pick_idx    = IDX_W'(i);
      end
    end
    any_free = |(~busy);
  end
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int N     = 3,
  parameter int IDX_W = 2,
  parameter int AGE_W = 2
) (
  input  logic [N-1:0]            ready,
  input  logic [N-1:0][AGE_W-1:0] ages,
  output logic [N-1:0]            sel_vec,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    any_ready
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    sel_vec   = '0;
    sel_idx   = '0;
    best_age  = '0;
    any_ready = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && (!any_ready || ages[i] > best_age)) begin
        any_ready = 1'b1;
        best_age  = ages[i];
        sel_idx   = IDX_W'(i);
      end
    end
    if (any_ready) sel_vec[sel_idx] = 1'b1;
  end
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int N_ENTRIES = 3,
  parameter int TAG_BASE  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [RS_OP_W-1:0]   disp_op,
  input  logic [RS_TAG_W-1:0]  disp_tag_a,
  input  logic [RS_DATA_W-1:0] disp_val_a,
  input  logic [RS_TAG_W-1:0]  disp_tag_b,
  input  logic [RS_DATA_W-1:0] disp_val_b,
  output logic                 full,
  output logic [RS_TAG_W-1:0]  disp_slot_tag,
  input  logic                 bc_valid,
  input  logic [RS_TAG_W-1:0]  bc_tag,
  input  logic [RS_DATA_W-1:0] bc_data,
  input  logic                 fu_free,
  output logic                 iss_valid,
  output logic [RS_OP_W-1:0]   iss_op,
  output logic [RS_DATA_W-1:0] iss_a,
  output logic [RS_DATA_W-1:0] iss_b,
  output logic [RS_TAG_W-1:0]  iss_tag
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int AGE_W = IDX_W;

  logic [N_ENTRIES-1:0]            busy, ready, free_vec, sel_vec;
  logic [N_ENTRIES-1:0]            alloc_vec, issue_vec;
  logic [N_ENTRIES-1:0][AGE_W-1:0] ages;
  op_t                             ops  [N_ENTRIES];
  data_t                           vals_a [N_ENTRIES];
  data_t                           vals_b [N_ENTRIES];
  logic [IDX_W-1:0]                free_idx, sel_idx;
  logic                            any_free, any_ready;
  logic                            disp_fire, iss_fire;
  opnd_t                           d_a, d_b;

  rs_alloc #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_alloc (
    .busy(busy), .pick_vec(free_vec), .pick_idx(free_idx), .any_free(any_free)
  );

  rs_select #(.N(N_ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_select (
    .ready(ready), .ages(ages), .sel_vec(sel_vec), .sel_idx(sel_idx),
    .any_ready(any_ready)
  );

  assign full          = !any_free;
  assign disp_fire     = disp_valid && any_free;
  assign alloc_vec     = disp_fire ? free_vec : '0;
  assign iss_fire      = fu_free && any_ready;
  assign issue_vec     = iss_fire ? sel_vec : '0;
  assign disp_slot_tag = RS_TAG_W'(TAG_BASE) + RS_TAG_W'(free_idx);
  assign d_a           = '{tag: disp_tag_a, val: disp_val_a};
  assign d_b           = '{tag: disp_tag_b, val: disp_val_b};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_st
    rs_entry #(.AGE_W(AGE_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[g]), .d_op(disp_op), .d_a(d_a), .d_b(d_b),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .issue_i(issue_vec[g]), .disp_ev(disp_fire), .iss_ev(iss_fire),
      .iss_age(ages[sel_idx]),
      .busy_o(busy[g]), .ready_o(ready[g]), .op_o(ops[g]),
      .a_o(vals_a[g]), .b_o(vals_b[g]), .age_o(ages[g])
    );
  end

  assign iss_valid = iss_fire;
  assign iss_op    = ops[sel_idx];
  assign iss_a     = vals_a[sel_idx];
  assign iss_b     = vals_b[sel_idx];
  assign iss_tag   = RS_TAG_W'(TAG_BASE) + RS_TAG_W'(sel_idx);

  // R7: nothing leaves while the unit is busy
  p_issue_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> fu_free);
  // R2: a full array writes no station
  p_no_alloc_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> alloc_vec == '0);
  // R3: at most one station is written per cycle
  p_alloc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));
  // R8: at most one station is issued per cycle
  p_issue_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec));
  // R2: full follows occupancy one cycle after a dispatch fills the last slot
  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busy) == N_ENTRIES - 1 && disp_fire && !iss_fire) |=> full);
endmodule

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 3;
  localparam int TB         = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        disp_valid;
  logic [3:0]  disp_op;
  logic [2:0]  disp_tag_a, disp_tag_b;
  logic [15:0] disp_val_a, disp_val_b;
  logic        full;
  logic [2:0]  disp_slot_tag;
  logic        bc_valid;
  logic [2:0]  bc_tag;
  logic [15:0] bc_data;
  logic        fu_free;
  logic        iss_valid;
  logic [3:0]  iss_op;
  logic [15:0] iss_a, iss_b;
  logic [2:0]  iss_tag;

  int checks = 0;
  int failures = 0;

  // bench model: occupancy, operands and dispatch sequence numbers
  bit        m_busy [N];
  int        m_op   [N];
  int        m_ta   [N];
  int        m_va   [N];
  int        m_tb   [N];
  int        m_vb   [N];
  int        m_seq  [N];
  int        seq_ctr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_array #(.N_ENTRIES(N), .TAG_BASE(TB)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_tag_a(disp_tag_a), .disp_val_a(disp_val_a),
    .disp_tag_b(disp_tag_b), .disp_val_b(disp_val_b),
    .full(full), .disp_slot_tag(disp_slot_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .fu_free(fu_free), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag)
  );

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int oldest_ready();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && m_ta[i] == 0 && m_tb[i] == 0)
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    return best;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_op = 0; disp_tag_a = 0; disp_val_a = 0;
    disp_tag_b = 0; disp_val_b = 0; bc_valid = 0; bc_tag = 0; bc_data = 0;
  endtask

  task automatic disp(int op, int ta, int va, int tb, int vb);
    disp_valid = 1; disp_op = 4'(op);
    disp_tag_a = 3'(ta); disp_val_a = 16'(va);
    disp_tag_b = 3'(tb); disp_val_b = 16'(vb);
  endtask

  task automatic bcast(int t, int d);
    bc_valid = 1; bc_tag = 3'(t); bc_data = 16'(d);
  endtask

  // inputs already driven after a falling edge; check, cross the edge, update model
  task automatic step(string req);
    int fr, rd;
    bit exp_full;
    #1;
    fr = lowest_free();
    rd = oldest_ready();
    exp_full = (fr < 0);
    check(req, "full", int'(full), int'(exp_full));
    if (!exp_full) check(req, "disp_slot_tag", int'(disp_slot_tag), TB + fr);
    check(req, "iss_valid", int'(iss_valid), int'(fu_free && rd >= 0));
    if (fu_free && rd >= 0) begin
      check(req, "iss_op", int'(iss_op), m_op[rd]);
      check(req, "iss_a", int'(iss_a), m_va[rd]);
      check(req, "iss_b", int'(iss_b), m_vb[rd]);
      check(req, "iss_tag", int'(iss_tag), TB + rd);
    end
    @(posedge clk);
    if (fu_free && rd >= 0) m_busy[rd] = 0;
    for (int i = 0; i < N; i++) begin
      if (m_busy[i] && bc_valid) begin
        if (m_ta[i] != 0 && m_ta[i] == int'(bc_tag)) begin m_ta[i] = 0; m_va[i] = int'(bc_data); end
        if (m_tb[i] != 0 && m_tb[i] == int'(bc_tag)) begin m_tb[i] = 0; m_vb[i] = int'(bc_data); end
      end
    end
    if (disp_valid && fr >= 0) begin
      m_busy[fr] = 1;
      m_op[fr]   = int'(disp_op);
      m_seq[fr]  = seq_ctr++;
      m_ta[fr] = int'(disp_tag_a); m_va[fr] = int'(disp_val_a);
      m_tb[fr] = int'(disp_tag_b); m_vb[fr] = int'(disp_val_b);
      if (bc_valid && m_ta[fr] != 0 && m_ta[fr] == int'(bc_tag)) begin m_ta[fr] = 0; m_va[fr] = int'(bc_data); end
      if (bc_valid && m_tb[fr] != 0 && m_tb[fr] == int'(bc_tag)) begin m_tb[fr] = 0; m_vb[fr] = int'(bc_data); end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_busy[i] = 0;
    rst_n = 0; fu_free = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    step("R1");
    // R4: valued operands stored; R7: held until the unit is free
    disp(1, 0, 11, 0, 22); step("R4");
    idle(); step("R7");
    fu_free = 1; step("R7");
    // R3: lowest free slot and its tag; R2: full, extra dispatch dropped
    fu_free = 0;
    disp(2, 6, 0, 0, 33); step("R3");
    disp(3, 7, 0, 0, 44); step("R3");
    disp(4, 6, 0, 7, 0);  step("R3");
    disp(5, 0, 1, 0, 2);  step("R2");
    idle(); step("R2");
    // R10: invalid or unmatched broadcasts change nothing
    fu_free = 1;
    bcast(5, 999); step("R10");
    idle(); bc_tag = 6; bc_data = 16'd777; step("R10");
    // R5: wakeups; R8: oldest first
    idle(); fu_free = 0; bcast(6, 100); step("R5");
    bcast(7, 200); step("R5");
    idle(); fu_free = 1;
    step("R8"); step("R8"); step("R8"); step("R8");
    // R6: dispatch meets its producer's broadcast in the same cycle
    fu_free = 0; disp(6, 5, 0, 0, 66); bcast(5, 55); step("R6");
    idle(); fu_free = 1; step("R6");
    // R9: issued slot reusable on the next cycle
    fu_free = 0;
    disp(7, 0, 1, 0, 1); step("R9");
    disp(8, 0, 2, 0, 2); step("R9");
    disp(9, 0, 3, 0, 3); step("R9");
    fu_free = 1; disp(10, 0, 4, 0, 4); step("R9");
    fu_free = 0; disp(11, 0, 5, 0, 5); step("R9");
    idle(); step("R9");
    fu_free = 1; repeat (4) step("R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(0, 99) < 55) begin
        disp(int'($urandom_range(0, 15)),
             ($urandom_range(0, 99) < 40) ? 0 : int'($urandom_range(1, 7)),
             int'($urandom_range(0, 65535)),
             ($urandom_range(0, 99) < 40) ? 0 : int'($urandom_range(1, 7)),
             int'($urandom_range(0, 65535)));
      end
      if ($urandom_range(0, 99) < 60)
        bcast(int'($urandom_range(1, 7)), int'($urandom_range(0, 65535)));
      fu_free = ($urandom_range(0, 99) < 60);
      step("R5");
    end

    // drain: wake every tag and issue everything
    idle(); fu_free = 1;
    for (int t = 1; t < 8; t++) begin bcast(t, t * 1000); step("R8"); end
    idle(); repeat (5) step("R8");
    finish_run();
  end
endmodule